// File: doc/BRIEF.md
# RTC Masked Alarm Match Unit

This block watches the running calendar time of a real-time clock and raises an alarm when that time reaches a programmed setting. Software loads four alarm bytes (seconds, minutes, hours, date) in BCD through a byte-wide register port. Each byte carries an ignore bit in its top position. A field whose ignore bit is set takes no part in the comparison, so an alarm can fire once a minute, once an hour, once a day and so on.

The timekeeping counters outside this block present the current BCD fields and a one-cycle seconds tick. The comparison is evaluated only on that tick, and it counts only when time moves into the matching state. The event sets a sticky alarm flag. Reading the status register clears the flag. An enable bit can route the event to an interrupt pin, whose active polarity and whose level or fixed-length pulse behaviour are programmable.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset the alarm flag is 0, every register reads back 0x00, and irq_out sits at its inactive level, which is 1 (active-low default).
- R2: The alarm bytes are at offset 2 (seconds), 3 (minutes), 4 (hours) and 5 (date). The interrupt control byte is at offset 6, with bit 6 as the enable, bit 2 as polarity (1 = active high) and bit 1 as mode (1 = pulse). Written values read back: the alarm bytes keep all 8 bits, and the control byte keeps only bits 6, 2 and 1. Writes to the status byte at offset 0 have no effect.
- R3: A field whose alarm byte has bit 7 = 0 matches only when bits 6:0 equal the current field. A field with bit 7 = 1 always matches.
- R4: The match is evaluated only in cycles with sec_tick = 1. The flag sets on the edge after a tick where all fields match and the previous tick did not match. A match that persists across ticks does not set the flag again.
- R5: A read (reg_rd = 1) returns data on reg_rdata at the next edge. The status byte at offset 0 shows the flag in bit 6 and 0 in all other bits. Reading it returns the value before the read and clears the flag.
- R6: When a flag-setting tick and a status read fall in the same cycle, the read returns the old flag and the flag ends up 1.
- R7: With the enable bit at 0, irq_out stays at its inactive level whatever the flag does.
- R8: In level mode with the enable bit at 1, irq_out is active exactly while the flag is 1.
- R9: In pulse mode with the enable bit at 1, irq_out is active for exactly PULSE_CYC cycles, starting on the edge after the setting tick.
- R10: With the polarity bit at 1, the active level of irq_out is 1. Otherwise it is 0.
- R11: Reads of offsets 1 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, updated on a read |
| cur_sec | input | 8 | Current BCD seconds |
| cur_min | input | 8 | Current BCD minutes |
| cur_hour | input | 8 | Current BCD hours |
| cur_date | input | 8 | Current BCD date |
| sec_tick | input | 1 | One-cycle strobe each second, current fields valid with it |
| irq_out | output | 1 | Interrupt pin |

## Verification
The assertions assume that sec_tick is a single-cycle strobe and that the current time fields are valid in that same cycle. They also assume that a status read and a status write are ordinary strobes with no further side effects. The stimulus keeps bit 7 of every current field at 0, as real BCD time would. It draws time values from a small set so that masked and unmasked matches both happen often. Register accesses are mixed randomly with ticks, including ticks that coincide with status reads, and directed sequences cover persistent matches and each interrupt mode.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned FIELDS   = 4;
  localparam int unsigned OFS_STAT = 0;
  localparam int unsigned OFS_ALM0 = 2;
  localparam int unsigned OFS_CTRL = 6;
  localparam int unsigned FLAG_BIT = 6;
  localparam int unsigned IE_BIT   = 6;
  localparam int unsigned POL_BIT  = 2;
  localparam int unsigned MODE_BIT = 1;

  typedef struct packed {
    logic ie;
    logic pol_hi;
    logic pulse_md;
  } irq_cfg_t;

  // one alarm field: top bit ignores, else the lower seven bits must agree
  function automatic logic field_hit(input logic [7:0] alm, input logic [7:0] cur);
    return alm[7] | (alm[6:0] == cur[6:0]);
  endfunction

  function automatic logic [7:0] cfg_to_byte(input irq_cfg_t c);
    logic [7:0] b;
    b = 8'h00;
    b[IE_BIT]   = c.ie;
    b[POL_BIT]  = c.pol_hi;
    b[MODE_BIT] = c.pulse_md;
    return b;
  endfunction

  function automatic irq_cfg_t byte_to_cfg(input logic [7:0] b);
    irq_cfg_t c;
    c.ie       = b[IE_BIT];
    c.pol_hi   = b[POL_BIT];
    c.pulse_md = b[MODE_BIT];
    return c;
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic                   rd,
  input  logic [AW-1:0]          addr,
  input  logic [7:0]             wdata,
  input  logic                   flag_in,
  output logic [FIELDS-1:0][7:0] alm,
  output irq_cfg_t               cfg,
  output logic [7:0]             rdata
);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);

  logic [7:0] rd_val;

  for (genvar gi = 0; gi < FIELDS; gi++) begin : g_alm
    localparam logic [AW-1:0] SLOT = AW'(OFS_ALM0 + gi);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  alm[gi] <= 8'h00;
      else if (wr && addr == SLOT) alm[gi] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cfg <= '0;
    else if (wr && addr == A_CTRL) cfg <= byte_to_cfg(wdata);
  end

  always_comb begin
    rd_val = 8'h00;
    if (addr == A_STAT) rd_val[FLAG_BIT] = flag_in;
    if (addr == A_CTRL) rd_val = cfg_to_byte(cfg);
    for (int i = 0; i < FIELDS; i++) begin
      if (addr == AW'(OFS_ALM0 + i)) rd_val = alm[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= 8'h00;
    else if (rd) rdata <= rd_val;
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sec_tick,
  input  logic [FIELDS-1:0][7:0] alm,
  input  logic [FIELDS-1:0][7:0] cur,
  output logic                   all_hit,
  output logic                   set_ev
);
  logic [FIELDS-1:0] hit;
  logic              prev_q;

  for (genvar gi = 0; gi < FIELDS; gi++) begin : g_hit
    assign hit[gi] = field_hit(alm[gi], cur[gi]);
  end

  assign all_hit = &hit;

  // remember the outcome of the last tick so only entry into a match counts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prev_q <= 1'b0;
    else if (sec_tick) prev_q <= all_hit;
  end

  assign set_ev = sec_tick & all_hit & ~prev_q;
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set_ev,
  input  logic     flags_rd,
  input  irq_cfg_t cfg,
  output logic     flag_q,
  output logic     irq_out
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] pulse_cnt;
  logic          irq_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (set_ev)   flag_q <= 1'b1;
    else if (flags_rd) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pulse_cnt <= '0;
    else if (set_ev)           pulse_cnt <= CW'(PULSE_CYC);
    else if (pulse_cnt != '0)  pulse_cnt <= pulse_cnt - 1'b1;
  end

  assign irq_act = cfg.ie & (cfg.pulse_md ? (pulse_cnt != '0) : flag_q);
  assign irq_out = cfg.pol_hi ? irq_act : ~irq_act;
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 8,
  parameter int unsigned AW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [7:0]    cur_sec,
  input  logic [7:0]    cur_min,
  input  logic [7:0]    cur_hour,
  input  logic [7:0]    cur_date,
  input  logic          sec_tick,
  output logic          irq_out
);
  logic [FIELDS-1:0][7:0] alm;
  logic [FIELDS-1:0][7:0] cur;
  irq_cfg_t               cfg;
  logic                   flag_q;
  logic                   set_ev;
  logic                   all_hit;
  logic                   flags_rd;
  logic                   ie;
  logic                   pol_hi;
  logic                   pulse_md;

  assign cur      = {cur_date, cur_hour, cur_min, cur_sec};
  assign flags_rd = reg_rd && (reg_addr == AW'(OFS_STAT));
  assign ie       = cfg.ie;
  assign pol_hi   = cfg.pol_hi;
  assign pulse_md = cfg.pulse_md;

  rtc_alarm_regs #(.AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .flag_in (flag_q),
    .alm     (alm),
    .cfg     (cfg),
    .rdata   (reg_rdata)
  );

  rtc_alarm_cmp u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .alm      (alm),
    .cur      (cur),
    .all_hit  (all_hit),
    .set_ev   (set_ev)
  );

  rtc_alarm_irq #(.PULSE_CYC(PULSE_CYC)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ev   (set_ev),
    .flags_rd (flags_rd),
    .cfg      (cfg),
    .flag_q   (flag_q),
    .irq_out  (irq_out)
  );
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk (
  input logic clk,
  input logic rst_n,
  input logic sec_tick,
  input logic flags_rd,
  input logic set_ev,
  input logic flag_q,
  input logic irq_out,
  input logic ie,
  input logic pol_hi,
  input logic pulse_md
);
  p_tick_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |-> !set_ev);

  p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_ev));

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_rd && !set_ev) |=> !flag_q);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag_q);

  p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> (irq_out == !pol_hi));

  p_level_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ie && !pulse_md) |-> ((irq_out == pol_hi) == flag_q));
endmodule

bind rtc_alarm_unit rtc_alarm_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sec_tick (sec_tick),
  .flags_rd (flags_rd),
  .set_ev   (set_ev),
  .flag_q   (flag_q),
  .irq_out  (irq_out),
  .ie       (ie),
  .pol_hi   (pol_hi),
  .pulse_md (pulse_md)
);

// File: tb/sim_rtc_alarm_unit.sv
module sim_rtc_alarm_unit;
  localparam int PCYC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
  logic       sec_tick = 1'b0;
  logic       irq_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rtc_alarm_unit #(.PULSE_CYC(PCYC)) u0 (.*);

  // bench-side model state, describing the design after the most recent edge
  logic [7:0] m_alm [4];
  logic m_ie, m_pol, m_pm, m_flag, m_prev;
  int   m_pulse;
  logic [7:0] m_rdata;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic fld_ok(input logic [7:0] a, input logic [7:0] c);
    if (a[7]) return 1'b1;
    return (a[6:4] == c[6:4]) && (a[3:0] == c[3:0]);
  endfunction

  function automatic logic [7:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {1'b0, m_flag, 6'b0};
      3'd2, 3'd3, 3'd4, 3'd5: return m_alm[a - 3'd2];
      3'd6: return {1'b0, m_ie, 3'b0, m_pol, m_pm, 1'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic model_irq();
    logic on;
    on = m_ie && (m_pm ? (m_pulse != 0) : m_flag);
    return m_pol ? on : !on;
  endfunction

  function automatic string irq_req();
    if (!m_ie) return "R7";
    if (m_pm)  return "R9";
    return m_pol ? "R10" : "R8";
  endfunction

  task automatic cyc(input logic tk, input logic [7:0] s, input logic [7:0] mi,
                     input logic [7:0] h, input logic [7:0] d, input logic rd,
                     input logic wr, input logic [2:0] a, input logic [7:0] wd,
                     input string req);
    logic hit, set;
    sec_tick = tk; cur_sec = s; cur_min = mi; cur_hour = h; cur_date = d;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    hit = fld_ok(m_alm[0], s) && fld_ok(m_alm[1], mi) &&
          fld_ok(m_alm[2], h) && fld_ok(m_alm[3], d);
    set = tk && hit && !m_prev;
    if (rd) m_rdata = model_read(a);
    if (tk) m_prev = hit;
    if (set) m_flag = 1'b1;
    else if (rd && a == 3'd0) m_flag = 1'b0;
    if (set) m_pulse = PCYC;
    else if (m_pulse > 0) m_pulse--;
    if (wr) begin
      if (a >= 3'd2 && a <= 3'd5) m_alm[a - 3'd2] = wd;
      if (a == 3'd6) begin m_ie = wd[6]; m_pol = wd[2]; m_pm = wd[1]; end
    end
    @(negedge clk);
    if (rd) chk(req, reg_rdata, m_rdata);
    chk(irq_req(), {7'b0, irq_out}, {7'b0, model_irq()});
  endtask

  task automatic rd_reg(input logic [2:0] a, input string req);
    cyc(1'b0, 8'h00, 8'h00, 8'h00, 8'h01, 1'b1, 1'b0, a, 8'h00, req);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
    cyc(1'b0, 8'h00, 8'h00, 8'h00, 8'h01, 1'b0, 1'b1, a, v, "R2");
  endtask

  task automatic tick_s(input logic [7:0] s, input logic rd);
    cyc(1'b1, s, 8'h00, 8'h00, 8'h01, rd, 1'b0, 3'd0, 8'h00, "R6");
  endtask

  function automatic logic [7:0] pick_time();
    case ($urandom % 4)
      0: return 8'h00;
      1: return 8'h07;
      2: return 8'h30;
      default: return 8'h59;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 4; i++) m_alm[i] = 8'h00;
    m_ie = 0; m_pol = 0; m_pm = 0; m_flag = 0; m_prev = 0; m_pulse = 0; m_rdata = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", {7'b0, irq_out}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) rd_reg(3'(a), "R1");

    // register access
    wr_reg(3'd2, 8'hA5); wr_reg(3'd3, 8'h3C); wr_reg(3'd4, 8'h12); wr_reg(3'd5, 8'h81);
    wr_reg(3'd6, 8'hFF);
    for (int a = 2; a < 7; a++) rd_reg(3'(a), "R2");
    wr_reg(3'd0, 8'hFF);
    rd_reg(3'd0, "R2");
    rd_reg(3'd1, "R11");
    rd_reg(3'd7, "R11");

    // seconds only, active-low level
    wr_reg(3'd2, 8'h30); wr_reg(3'd3, 8'h80); wr_reg(3'd4, 8'h80); wr_reg(3'd5, 8'h80);
    wr_reg(3'd6, 8'h40);
    tick_s(8'h29, 1'b0);
    rd_reg(3'd0, "R3");
    tick_s(8'h30, 1'b0);
    chk("R8", {7'b0, irq_out}, 8'h00);
    rd_reg(3'd0, "R5");
    rd_reg(3'd0, "R5");
    // persistent match does not retrigger
    tick_s(8'h30, 1'b0);
    rd_reg(3'd0, "R4");
    tick_s(8'h31, 1'b0);
    cyc(1'b0, 8'h30, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0, 3'd0, 8'h00, "R4");
    rd_reg(3'd0, "R4");
    // set and read together
    tick_s(8'h30, 1'b1);
    rd_reg(3'd0, "R6");
    // pulse mode
    wr_reg(3'd6, 8'h42);
    tick_s(8'h31, 1'b0);
    tick_s(8'h30, 1'b0);
    chk("R9", {7'b0, irq_out}, 8'h00);
    repeat (PCYC + 2) rd_reg(3'd1, "R9");
    chk("R9", {7'b0, irq_out}, 8'h01);
    // active high level
    wr_reg(3'd6, 8'h44);
    tick_s(8'h31, 1'b0);
    tick_s(8'h30, 1'b0);
    chk("R10", {7'b0, irq_out}, 8'h01);
    rd_reg(3'd0, "R10");
    chk("R10", {7'b0, irq_out}, 8'h00);
    // disabled
    wr_reg(3'd6, 8'h00);
    tick_s(8'h31, 1'b0);
    tick_s(8'h30, 1'b0);
    chk("R7", {7'b0, irq_out}, 8'h01);
    rd_reg(3'd0, "R7");

    // constrained random
    for (int n = 0; n < 6000; n++) begin
      logic tk, rd, wr;
      logic [2:0] a;
      logic [7:0] wd;
      tk = ($urandom % 3) == 0;
      rd = ($urandom % 6) == 0;
      wr = ($urandom % 10) == 0;
      a  = (($urandom % 2) == 0) ? 3'd0 : 3'($urandom % 8);
      if (a == 3'd6) wd = 8'($urandom) & 8'h46;
      else           wd = pick_time() | ((($urandom % 2) == 0) ? 8'h80 : 8'h00);
      cyc(tk, pick_time(), pick_time(), (($urandom % 2) == 0) ? 8'h00 : 8'h12,
          (($urandom % 2) == 0) ? 8'h01 : 8'h15, rd, wr, a, wd,
          (a == 3'd0) ? "R5" : "R2");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule